// File: doc/BRIEF.md
# Power-Mode Controller

This block sequences the low-power states of a small microcontroller core. A one-cycle sleep strobe from the core moves it out of full-power Run. The idle-enable input decides which low-power state it enters. With idle-enable clear, the block enters Sleep: both clock domains are stopped and the primary oscillator is turned off. With idle-enable set, the block enters Idle: only the CPU clock is gated, and the peripherals run from the source chosen by a two-bit select that is captured when Idle is entered.

The block leaves Idle or Sleep only on an interrupt, a watchdog expiry or a reset. After a wake from Idle, the CPU and peripherals run from the captured Idle source until the primary oscillator reports ready, and then move to the primary clock. After a wake from Sleep, the system stays unclocked until the primary oscillator is ready. The exception is when fast start is enabled, in which case the internal oscillator clocks the system during that wait.

A watchdog expiry while the CPU is running is turned into a reset request rather than a wake. After every wake, and after reset, a parameterised start delay holds back the CPU-execute-ready output. The oscillators, the clock multiplexer itself and the watchdog counter live outside this block and appear only as enable and ready signals.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is active and after it is released, the block is in Run: both clocks are enabled on the primary source (code 00), the oscillator-start status is 0, and CPU-execute-ready stays low for START_DLY cycles after the release edge.
- R2: A sleep strobe in Run with idle-enable clear enters Sleep on the next clock edge. Both clocks are disabled, the primary-oscillator enable is deasserted and the oscillator-start status is cleared.
- R3: A sleep strobe in Run with idle-enable set enters Idle. The CPU clock is disabled and the peripheral clock stays enabled on the source captured from the select. Select 00 gives output code 00 (primary), 01 gives 01 (secondary), and 10 or 11 give 10 (internal). A disabled clock reports source code 00, and output code 11 never appears.
- R4: In Idle or Sleep, a further sleep strobe is ignored and the clock outputs do not change. In Run, an interrupt has no effect.
- R5: A watchdog expiry in Run or in a wake state produces a one-cycle reset request on the next edge and does not change the mode. In Idle or Sleep, a watchdog expiry wakes the block and raises no request.
- R6: After a wake from Sleep with fast start disabled, both clocks stay disabled until the primary oscillator reports ready. On that edge the block returns to Run on the primary source.
- R7: After a wake from Sleep with fast start enabled, both clocks run on the internal source (code 10) until the primary oscillator reports ready, and then switch to primary.
- R8: After a wake from Idle, both clocks run on the captured Idle source until the primary oscillator reports ready, and then switch to primary.
- R9: The oscillator-start status rises on the edge after which the primary oscillator was ready while enabled. It falls only on Sleep entry or reset.
- R10: A wake event reloads the start delay. CPU-execute-ready is high only when the delay has expired and the CPU clock is enabled, so it is low for exactly START_DLY cycles after a wake into a clocked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the reset wake source |
| sleep_req | input | 1 | One-cycle sleep strobe from the core |
| idle_en | input | 1 | Select Idle (1) or Sleep (0) on the sleep strobe |
| src_sel | input | 2 | Idle clock-source select: 00 primary, 01 secondary, 1x internal |
| irq | input | 1 | Interrupt wake request |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| pri_osc_ready | input | 1 | Primary oscillator stable |
| fast_start_en | input | 1 | Clock from the internal oscillator while the primary starts after Sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_clk_src | output | 2 | CPU clock source code |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_clk_src | output | 2 | Peripheral clock source code |
| pri_osc_en | output | 1 | Primary oscillator enable |
| osc_start_stat | output | 1 | Primary clock is running the system |
| wdt_rst_req | output | 1 | Reset request from a watchdog expiry in Run |
| cpu_exec_ready | output | 1 | CPU may execute |

## Verification
The bench builds the block with START_DLY = 6 and ALLOW_FAST_START = 1. The short delay means the full start-delay window after a reset or a wake can be counted cycle by cycle, and the delay can be seen both expiring before and running past the primary-ready handover. Keeping fast start in the build lets one run cover both Sleep wake paths: the unclocked wait and the internal-oscillator fallback. The bench also forces the oscillator-ready input low during Idle, so the handover from the Idle source back to primary can be observed.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      PM_RUN      = 3'd0,
      PM_IDLE     = 3'd1,
      PM_SLEEP    = 3'd2,
      PM_WAKE_SLP = 3'd3,
      PM_WAKE_IDL = 3'd4
   } pm_state_t;

   typedef enum logic [1:0] {
      CK_PRI = 2'b00,
      CK_SEC = 2'b01,
      CK_INT = 2'b10
   } ck_src_t;

   // Map the software select onto a source code; both 1x values pick internal.
   function automatic ck_src_t sel_to_src(input logic [1:0] sel);
      if (sel[1])      return CK_INT;
      else if (sel[0]) return CK_SEC;
      else             return CK_PRI;
   endfunction

   function automatic logic is_low_power(input pm_state_t s);
      return (s == PM_IDLE) || (s == PM_SLEEP);
   endfunction

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       idle_en,
   input  logic [1:0] src_sel,
   input  logic       irq,
   input  logic       wdt_expire,
   input  logic       pri_osc_ready,
   output pm_state_t  state,
   output ck_src_t    idle_src,
   output logic       enter_sleep,
   output logic       wake_evt
);

   pm_state_t nxt;
   logic      enter_idle;
   logic      wake_any;

   assign wake_any = irq | wdt_expire;

   always_comb begin
      nxt         = state;
      enter_sleep = 1'b0;
      enter_idle  = 1'b0;
      wake_evt    = 1'b0;
      case (state)
         PM_RUN: begin
            // A simultaneous watchdog expiry takes precedence over the strobe.
            if (sleep_req && !wdt_expire) begin
               if (idle_en) begin
                  nxt        = PM_IDLE;
                  enter_idle = 1'b1;
               end else begin
                  nxt         = PM_SLEEP;
                  enter_sleep = 1'b1;
               end
            end
         end
         PM_IDLE: begin
            if (wake_any) begin
               nxt      = PM_WAKE_IDL;
               wake_evt = 1'b1;
            end
         end
         PM_SLEEP: begin
            if (wake_any) begin
               nxt      = PM_WAKE_SLP;
               wake_evt = 1'b1;
            end
         end
         PM_WAKE_SLP, PM_WAKE_IDL: begin
            if (pri_osc_ready) nxt = PM_RUN;
         end
         default: nxt = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PM_RUN;
         idle_src <= CK_PRI;
      end else begin
         state <= nxt;
         if (enter_idle) idle_src <= sel_to_src(src_sel);
      end
   end

endmodule

// File: rtl/pwr_start_timer.sv
module pwr_start_timer #(
   parameter int START_DLY = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);

   localparam int CNT_W = $clog2(START_DLY + 1);

   logic [CNT_W-1:0] cnt;

   assign done = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= CNT_W'(START_DLY);
      else if (load)  cnt <= CNT_W'(START_DLY);
      else if (!done) cnt <= cnt - CNT_W'(1);
   end

endmodule

// File: rtl/pwr_clk_route.sv
module pwr_clk_route
   import pwr_mode_pkg::*;
#(
   parameter bit ALLOW_FAST_START = 1'b1
) (
   input  pm_state_t  state,
   input  ck_src_t    idle_src,
   input  logic       fast_start_en,
   output logic       cpu_en,
   output logic [1:0] cpu_src,
   output logic       per_en,
   output logic [1:0] per_src,
   output logic       pri_en
);

   logic fast_eff;

   generate
      if (ALLOW_FAST_START) begin : g_fast
         assign fast_eff = fast_start_en;
      end else begin : g_no_fast
         assign fast_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      cpu_en  = 1'b0;
      cpu_src = CK_PRI;
      per_en  = 1'b0;
      per_src = CK_PRI;
      pri_en  = 1'b1;
      case (state)
         PM_RUN: begin
            cpu_en = 1'b1;
            per_en = 1'b1;
         end
         PM_IDLE: begin
            per_en  = 1'b1;
            per_src = idle_src;
         end
         PM_SLEEP: begin
            pri_en = 1'b0;
         end
         PM_WAKE_SLP: begin
            if (fast_eff) begin
               cpu_en  = 1'b1;
               cpu_src = CK_INT;
               per_en  = 1'b1;
               per_src = CK_INT;
            end
         end
         PM_WAKE_IDL: begin
            cpu_en  = 1'b1;
            cpu_src = idle_src;
            per_en  = 1'b1;
            per_src = idle_src;
         end
         default: begin
            cpu_en = 1'b1;
            per_en = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pwr_mode_pkg::*;
#(
   parameter int START_DLY        = 80,
   parameter bit ALLOW_FAST_START = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       idle_en,
   input  logic [1:0] src_sel,
   input  logic       irq,
   input  logic       wdt_expire,
   input  logic       pri_osc_ready,
   input  logic       fast_start_en,
   output logic       cpu_clk_en,
   output logic [1:0] cpu_clk_src,
   output logic       per_clk_en,
   output logic [1:0] per_clk_src,
   output logic       pri_osc_en,
   output logic       osc_start_stat,
   output logic       wdt_rst_req,
   output logic       cpu_exec_ready
);

   localparam int MAX_DLY = 1 << 20;

   generate
      if (START_DLY < 1) begin : g_bad_dly_low
         $error("pwr_mode_ctl: START_DLY must be at least 1");
      end
      if (START_DLY > MAX_DLY) begin : g_bad_dly_high
         $error("pwr_mode_ctl: START_DLY exceeds supported range");
      end
   endgenerate

   pm_state_t state;
   ck_src_t   idle_src;
   logic      enter_sleep;
   logic      wake_evt;
   logic      dly_done;
   logic      stat_q;
   logic      wdt_q;

   pwr_mode_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .sleep_req     (sleep_req),
      .idle_en       (idle_en),
      .src_sel       (src_sel),
      .irq           (irq),
      .wdt_expire    (wdt_expire),
      .pri_osc_ready (pri_osc_ready),
      .state         (state),
      .idle_src      (idle_src),
      .enter_sleep   (enter_sleep),
      .wake_evt      (wake_evt)
   );

   pwr_start_timer #(.START_DLY(START_DLY)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wake_evt),
      .done  (dly_done)
   );

   pwr_clk_route #(.ALLOW_FAST_START(ALLOW_FAST_START)) u_route (
      .state         (state),
      .idle_src      (idle_src),
      .fast_start_en (fast_start_en),
      .cpu_en        (cpu_clk_en),
      .cpu_src       (cpu_clk_src),
      .per_en        (per_clk_en),
      .per_src       (per_clk_src),
      .pri_en        (pri_osc_en)
   );

   // Oscillator-start status: cleared on Sleep entry, set once primary is up.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          stat_q <= 1'b0;
      else if (enter_sleep)                stat_q <= 1'b0;
      else if (pri_osc_en && pri_osc_ready) stat_q <= 1'b1;
   end

   // Watchdog expiry is a reset request only while the CPU is running.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdt_q <= 1'b0;
      else        wdt_q <= wdt_expire && !is_low_power(state);
   end

   assign osc_start_stat = stat_q;
   assign wdt_rst_req    = wdt_q;
   assign cpu_exec_ready = dly_done && cpu_clk_en;

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wdt_expire,
   input logic       pri_osc_ready,
   input logic       cpu_clk_en,
   input logic [1:0] cpu_clk_src,
   input logic       per_clk_en,
   input logic [1:0] per_clk_src,
   input logic       pri_osc_en,
   input logic       osc_start_stat,
   input logic       wdt_rst_req,
   input logic       cpu_exec_ready
);

   // R2
   osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pri_osc_en |-> (!cpu_clk_en && !per_clk_en && !osc_start_stat));

   // R3
   cpu_needs_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (per_clk_en && cpu_clk_src == per_clk_src));

   // R3
   src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_clk_src != 2'b11) && (cpu_clk_src != 2'b11));

   // R5
   wdt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |-> $past(wdt_expire));

   // R9
   stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_start_stat) |-> $past(pri_osc_ready));

   // R10
   exec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_exec_ready |-> cpu_clk_en);

endmodule

bind pwr_mode_ctl pwr_mode_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wdt_expire     (wdt_expire),
   .pri_osc_ready  (pri_osc_ready),
   .cpu_clk_en     (cpu_clk_en),
   .cpu_clk_src    (cpu_clk_src),
   .per_clk_en     (per_clk_en),
   .per_clk_src    (per_clk_src),
   .pri_osc_en     (pri_osc_en),
   .osc_start_stat (osc_start_stat),
   .wdt_rst_req    (wdt_rst_req),
   .cpu_exec_ready (cpu_exec_ready)
);

// File: tb/tb_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctl;

   localparam int DLY = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, idle_en = 1'b0, irq = 1'b0, wdt_expire = 1'b0;
   logic pri_osc_ready = 1'b0, fast_start_en = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic cpu_clk_en, per_clk_en, pri_osc_en, osc_start_stat, wdt_rst_req, cpu_exec_ready;
   logic [1:0] cpu_clk_src, per_clk_src;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   pwr_mode_ctl #(.START_DLY(DLY), .ALLOW_FAST_START(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
      .src_sel(src_sel), .irq(irq), .wdt_expire(wdt_expire),
      .pri_osc_ready(pri_osc_ready), .fast_start_en(fast_start_en),
      .cpu_clk_en(cpu_clk_en), .cpu_clk_src(cpu_clk_src),
      .per_clk_en(per_clk_en), .per_clk_src(per_clk_src),
      .pri_osc_en(pri_osc_en), .osc_start_stat(osc_start_stat),
      .wdt_rst_req(wdt_rst_req), .cpu_exec_ready(cpu_exec_ready)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: 0 run, 1 idle, 2 sleep, 3 waking from sleep, 4 waking from idle
   int m_mode = 0;
   int m_isrc = 0;
   int m_cnt = DLY;
   bit m_stat = 0;
   bit m_wdt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_isrc = 0; m_cnt = DLY; m_stat = 0; m_wdt = 0;
      end else begin
         bit low_pwr, osc_on, reload;
         low_pwr = (m_mode == 1) || (m_mode == 2);
         osc_on  = (m_mode != 2);
         reload  = 0;
         m_wdt   = wdt_expire && !low_pwr;
         if (osc_on && pri_osc_ready) m_stat = 1;
         if (m_mode == 0 && sleep_req && !wdt_expire) begin
            if (idle_en) begin
               m_mode = 1;
               m_isrc = src_sel[1] ? 2 : (src_sel[0] ? 1 : 0);
            end else begin
               m_mode = 2;
               m_stat = 0;
            end
         end else if (low_pwr && (irq || wdt_expire)) begin
            m_mode = (m_mode == 2) ? 3 : 4;
            reload = 1;
         end else if ((m_mode == 3 || m_mode == 4) && pri_osc_ready) begin
            m_mode = 0;
         end
         if (reload) m_cnt = DLY;
         else if (m_cnt > 0) m_cnt--;
      end
   end

   always @(posedge clk) begin
      #2;
      if (!finished) begin
         int ce, cs, pe, ps, pen;
         ce = 0; cs = 0; pe = 0; ps = 0; pen = 1;
         case (m_mode)
            0: begin ce = 1; pe = 1; end
            1: begin pe = 1; ps = m_isrc; end
            2: pen = 0;
            3: if (fast_start_en) begin ce = 1; cs = 2; pe = 1; ps = 2; end
            default: begin ce = 1; cs = m_isrc; pe = 1; ps = m_isrc; end
         endcase
         check("R3 cpu_clk_en", cpu_clk_en, ce);
         check("R8 cpu_clk_src", cpu_clk_src, cs);
         check("R3 per_clk_en", per_clk_en, pe);
         check("R8 per_clk_src", per_clk_src, ps);
         check("R2 pri_osc_en", pri_osc_en, pen);
         check("R9 osc_start_stat", osc_start_stat, m_stat);
         check("R5 wdt_rst_req", wdt_rst_req, m_wdt);
         check("R10 cpu_exec_ready", cpu_exec_ready, (m_cnt == 0 && ce == 1) ? 1 : 0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
   endtask

   task automatic pulse_irq();
      @(negedge clk) irq = 1'b1;
      @(negedge clk) irq = 1'b0;
   endtask

   task automatic pulse_wdt();
      @(negedge clk) wdt_expire = 1'b1;
      @(negedge clk) wdt_expire = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      check("R1 cpu on primary", cpu_clk_src, 0);
      check("R1 status clear", osc_start_stat, 0);
      check("R1 exec held", cpu_exec_ready, 0);
      pri_osc_ready = 1'b1;
      step(8);
      check("R1 exec after delay", cpu_exec_ready, 1);
      check("R9 status set", osc_start_stat, 1);

      // R4: interrupt in Run has no effect
      pulse_irq();
      check("R4 irq in run", cpu_clk_en, 1);

      // Idle on secondary
      idle_en = 1'b1; src_sel = 2'b01;
      pulse_sleep();
      step(1);
      check("R3 idle cpu off", cpu_clk_en, 0);
      check("R3 idle per src", per_clk_src, 1);
      pulse_sleep();
      step(1);
      check("R4 strobe ignored per", per_clk_en, 1);
      check("R4 strobe ignored cpu", cpu_clk_en, 0);
      pri_osc_ready = 1'b0;
      pulse_irq();
      begin
         int lows;
         lows = 0;
         check("R8 wake idle src", cpu_clk_src, 1);
         while (!cpu_exec_ready && lows < 50) begin
            lows++;
            @(negedge clk);
         end
         check("R10 start delay cycles", lows, DLY);
      end
      pri_osc_ready = 1'b1;
      step(2);
      check("R8 handover to primary", cpu_clk_src, 0);

      // Idle on internal via select 11, watchdog wake
      src_sel = 2'b11;
      pulse_sleep();
      step(1);
      check("R3 select 11 internal", per_clk_src, 2);
      pulse_wdt();
      check("R5 no request on wake", wdt_rst_req, 0);
      step(10);

      // Sleep without fast start
      idle_en = 1'b0; src_sel = 2'b00;
      pulse_sleep();
      check("R2 osc off", pri_osc_en, 0);
      check("R2 status cleared", osc_start_stat, 0);
      pri_osc_ready = 1'b0;
      step(3);
      pulse_wdt();
      step(3);
      check("R6 clocks held off", cpu_clk_en, 0);
      pri_osc_ready = 1'b1;
      step(2);
      check("R6 run on primary", cpu_clk_en, 1);
      step(10);

      // Sleep with fast start
      fast_start_en = 1'b1;
      pulse_sleep();
      pri_osc_ready = 1'b0;
      step(3);
      pulse_irq();
      step(2);
      check("R7 internal fallback", cpu_clk_src, 2);
      pri_osc_ready = 1'b1;
      step(2);
      check("R7 switch to primary", cpu_clk_src, 0);
      step(10);
      fast_start_en = 1'b0;

      // Watchdog in Run requests reset
      @(negedge clk) wdt_expire = 1'b1;
      @(posedge clk) #2;
      check("R5 run request", wdt_rst_req, 1);
      check("R5 mode unchanged", cpu_clk_en, 1);
      @(negedge clk) wdt_expire = 1'b0;

      // Watchdog and sleep strobe together: watchdog wins
      @(negedge clk) begin wdt_expire = 1'b1; sleep_req = 1'b1; end
      @(negedge clk) begin wdt_expire = 1'b0; sleep_req = 1'b0; end
      check("R5 strobe dropped", pri_osc_en, 1);
      step(4);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule